// File: doc/BRIEF.md
# Paged Byte Router

This block connects a host port that issues 8-, 16- or 32-bit accesses to three byte-wide register targets. Each host access is cut into single-byte sub-accesses, one per clock, at ascending addresses, with the lowest byte lane first. For every byte, the block looks at the page bits of the address (all bits above bit 7) and steers the byte to one target. Page 0 goes to the system control target. Page 1 goes to the NAND configuration target. Any other page goes to the NAND register window, but only when that page equals a base value supplied at run time and the window enable is high.

Bytes that no target claims behave as follows. A read returns zero in its lane. A write is dropped and increments a saturating drop counter. Read bytes are packed little-endian into the host read word. A one-cycle done pulse marks the end of each access. The targets answer with combinational read data during the cycle in which they are selected, and they take write data at the clock edge that ends that cycle.

Top module: `paged_byte_router`

## Requirements
- R1: A byte whose address page (bits 15:8) is 0 asserts `sys_sel`, with `tgt_off` equal to address bits 7:0.
- R2: A byte whose address page is 1 asserts `cfg_sel`, with `tgt_off` equal to address bits 7:0.
- R3: A byte on any other page asserts `win_sel` only when that page equals `win_base` and `win_en` is 1. When `win_en` is 0, no target is selected for that byte.
- R4: Pages 0 and 1 keep their fixed targets even when `win_base` equals 0 or 1 and `win_en` is 1.
- R5: A read byte that no target claims returns 0x00 in its lane of `host_rdata`.
- R6: Each unclaimed write byte asserts no select signal and adds one to `drop_count`. The counter stops at its maximum value (255 by default).
- R7: `host_size` uses this encoding: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. Sub-accesses go out on consecutive clocks at addr, addr+1, and so on, wrapping within the 16-bit address. Byte k carries `host_wdata[8k+7:8k]` on `tgt_wdata`.
- R8: Byte k of a read lands in `host_rdata[8k+7:8k]`. Lanes beyond the access size read zero. A write access leaves `host_rdata` at zero.
- R9: `host_busy` is high during exactly the sub-access cycles. `host_done` pulses for one cycle in the cycle after the last byte. A request made while busy is ignored, and no select signal is asserted while idle.
- R10: After reset, `host_busy`, `host_done`, all select signals, `host_rdata` and `drop_count` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Start an access (sampled while idle) |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | Access size code (see R7) |
| host_addr | input | 16 | Byte address of lane 0 |
| host_wdata | input | 32 | Write data, little-endian lanes |
| host_busy | output | 1 | Sub-accesses in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Assembled read data |
| win_base | input | 8 | Page number of the NAND register window |
| win_en | input | 1 | NAND window enable |
| sys_sel | output | 1 | System control target selected |
| cfg_sel | output | 1 | NAND configuration target selected |
| win_sel | output | 1 | NAND register window selected |
| tgt_we | output | 1 | Current byte is a write |
| tgt_off | output | 8 | Byte offset within the page |
| tgt_wdata | output | 8 | Byte write data |
| sys_rdata | input | 8 | System control read byte |
| cfg_rdata | input | 8 | NAND configuration read byte |
| win_rdata | input | 8 | NAND window read byte |
| drop_count | output | 8 | Saturating count of unclaimed write bytes |

## Verification
The hardest case to reach is a single wide access whose bytes fall into different targets. Examples are a word that starts two bytes below a page boundary, and a word that wraps from the top of the address space into page 0 while the window sits on the top page. The stimulus places base addresses at 0x00FE and 0xFFFE to produce these cases. It also moves the window base onto the fixed pages to show that fixed decode has priority. The drop counter is driven into saturation by a long run of word writes to a disabled window page. A request pulse injected in the middle of a busy access shows that extra requests are ignored.

// File: rtl/pgdec_pkg.sv
// Shared types for the paged byte router.
// Assumes a host data path of four byte lanes.
package pgdec_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WORD_ALT = 2'd3
    } acc_size_t;

    // Number of byte sub-accesses for a size code, minus one.
    function automatic logic [1:0] last_lane(input logic [1:0] size);
        case (size)
            SZ_BYTE: last_lane = 2'd0;
            SZ_HALF: last_lane = 2'd1;
            default: last_lane = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/access_sequencer.sv
// Access sequencer: accepts one host access while idle and walks its bytes,
// one per clock, from the start address upward. It raises done for one cycle
// after the last byte. It assumes the targets finish each byte in one cycle.
module access_sequencer #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          accept,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] cur_addr,
    output logic          cur_we,
    output logic [7:0]    cur_wdata,
    output logic [$clog2(DW/8)-1:0] lane
);
    import pgdec_pkg::*;

    localparam int LANES = DW / 8;
    localparam int IW    = $clog2(LANES);

    logic          busy_q;
    logic          done_q;
    logic          we_q;
    logic [AW-1:0] base_q;
    logic [DW-1:0] wdata_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] last_q;

    assign accept = req && !busy_q;

    // Capture a new access, step through its bytes, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            we_q    <= 1'b0;
            base_q  <= '0;
            wdata_q <= '0;
            idx_q   <= '0;
            last_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (req) begin
                    busy_q  <= 1'b1;
                    we_q    <= we;
                    base_q  <= addr;
                    wdata_q <= wdata;
                    idx_q   <= '0;
                    last_q  <= IW'(last_lane(size));
                end
            end else if (idx_q == last_q) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Present the current byte address and its write lane.
    always_comb begin
        cur_addr  = base_q + AW'(idx_q);
        cur_wdata = wdata_q[{idx_q, 3'b000} +: 8];
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign cur_we = we_q;
    assign lane   = idx_q;

    p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx_q <= last_q));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q));
    p_busy_holds_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(base_q));

endmodule

// File: rtl/page_decoder.sv
// Page decoder: maps the current byte address to one target. The fixed pages
// 0 and 1 are tested before the programmable window. It assumes active is low
// whenever no byte is in flight.
module page_decoder #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [AW-1:0] addr,
    input  logic [AW-9:0] win_base,
    input  logic          win_en,
    output logic          sys_sel,
    output logic          cfg_sel,
    output logic          win_sel,
    output logic          claimed,
    output logic [7:0]    offset
);
    localparam int PW = AW - 8;

    logic [PW-1:0] page;

    assign page   = addr[AW-1:8];
    assign offset = addr[7:0];

    // Priority decode: system page, then config page, then the window.
    always_comb begin
        sys_sel = 1'b0;
        cfg_sel = 1'b0;
        win_sel = 1'b0;
        if (active) begin
            if (page == PW'(0))
                sys_sel = 1'b1;
            else if (page == PW'(1))
                cfg_sel = 1'b1;
            else if (win_en && (page == win_base))
                win_sel = 1'b1;
        end
    end

    assign claimed = sys_sel || cfg_sel || win_sel;

    p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_sel, cfg_sel, win_sel}));
    p_window_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel |-> win_en);
    p_fixed_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && addr[AW-1:8] == PW'(0)) |-> sys_sel);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !(sys_sel || cfg_sel || win_sel));

endmodule

// File: rtl/read_assembler.sv
// Read assembler: one byte register per lane. It clears all lanes when an
// access is accepted and loads the lane named by the sequencer on each read
// byte. It assumes byte_in is already zero for unclaimed bytes.
module read_assembler #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          capture,
    input  logic [$clog2(DW/8)-1:0] lane,
    input  logic [7:0]    byte_in,
    output logic [DW-1:0] rdata
);
    localparam int LANES = DW / 8;
    localparam int IW    = $clog2(LANES);

    logic [7:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Hold one byte lane of the host read word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= '0;
            else if (start)
                lane_q[g] <= '0;
            else if (capture && lane == IW'(g))
                lane_q[g] <= byte_in;
        end
        assign rdata[g*8 +: 8] = lane_q[g];
    end

    p_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rdata == '0));
    p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !capture) |=> $stable(rdata));

endmodule

// File: rtl/drop_counter.sv
// Drop counter: counts dropped write bytes and saturates at all ones.
// It assumes at most one drop per clock.
module drop_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] MAXV = '1;

    logic [CW-1:0] cnt_q;

    // Saturating increment on each dropped byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hit && cnt_q != MAXV)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cnt_q));
    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV) |=> (cnt_q == MAXV));

endmodule

// File: rtl/paged_byte_router.sv
// Paged byte router top: splits host accesses into bytes, decodes each byte
// to one of three byte targets, packs read data and counts dropped writes.
// It assumes the targets return read data combinationally in the select cycle.
module paged_byte_router #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [1:0]    host_size,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_busy,
    output logic          host_done,
    output logic [DW-1:0] host_rdata,
    input  logic [AW-9:0] win_base,
    input  logic          win_en,
    output logic          sys_sel,
    output logic          cfg_sel,
    output logic          win_sel,
    output logic          tgt_we,
    output logic [7:0]    tgt_off,
    output logic [7:0]    tgt_wdata,
    input  logic [7:0]    sys_rdata,
    input  logic [7:0]    cfg_rdata,
    input  logic [7:0]    win_rdata,
    output logic [CW-1:0] drop_count
);
    localparam int IW = $clog2(DW / 8);

    logic          accept;
    logic          busy;
    logic          cur_we;
    logic [AW-1:0] cur_addr;
    logic [7:0]    cur_wdata;
    logic [IW-1:0] lane;
    logic          claimed;
    logic [7:0]    rd_byte;

    access_sequencer #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req(host_req), .we(host_we), .size(host_size),
        .addr(host_addr), .wdata(host_wdata),
        .accept(accept), .busy(busy), .done(host_done),
        .cur_addr(cur_addr), .cur_we(cur_we), .cur_wdata(cur_wdata),
        .lane(lane)
    );

    page_decoder #(.AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .active(busy), .addr(cur_addr),
        .win_base(win_base), .win_en(win_en),
        .sys_sel(sys_sel), .cfg_sel(cfg_sel), .win_sel(win_sel),
        .claimed(claimed), .offset(tgt_off)
    );

    // Pick the read byte of the selected target, zero when unclaimed.
    always_comb begin
        if (sys_sel)
            rd_byte = sys_rdata;
        else if (cfg_sel)
            rd_byte = cfg_rdata;
        else if (win_sel)
            rd_byte = win_rdata;
        else
            rd_byte = 8'h00;
    end

    read_assembler #(.DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .start(accept), .capture(busy && !cur_we),
        .lane(lane), .byte_in(rd_byte), .rdata(host_rdata)
    );

    drop_counter #(.CW(CW)) u_drop (
        .clk(clk), .rst_n(rst_n),
        .hit(busy && cur_we && !claimed),
        .count(drop_count)
    );

    assign host_busy = busy;
    assign tgt_we    = busy && cur_we;
    assign tgt_wdata = cur_wdata;

    p_write_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_we |-> host_busy);

endmodule

// File: tb/paged_byte_router_tb_top.sv
// Scoreboard bench: the driver pushes the expected byte events, and a monitor
// pops and compares them against what the router shows at the target side.
module paged_byte_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_size = 2'd0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_busy, host_done;
    logic [31:0] host_rdata;
    logic [7:0]  win_base = 8'h00;
    logic        win_en = 1'b0;
    logic        sys_sel, cfg_sel, win_sel, tgt_we;
    logic [7:0]  tgt_off, tgt_wdata;
    logic [7:0]  sys_rdata, cfg_rdata, win_rdata;
    logic [7:0]  drop_count;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_drops = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Simple byte target models with distinct, offset-dependent read data.
    assign sys_rdata = tgt_off ^ 8'h5A;
    assign cfg_rdata = tgt_off + 8'h30;
    assign win_rdata = ~tgt_off;

    paged_byte_router #(.AW(AW), .DW(32), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_size(host_size),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata),
        .win_base(win_base), .win_en(win_en),
        .sys_sel(sys_sel), .cfg_sel(cfg_sel), .win_sel(win_sel),
        .tgt_we(tgt_we), .tgt_off(tgt_off), .tgt_wdata(tgt_wdata),
        .sys_rdata(sys_rdata), .cfg_rdata(cfg_rdata), .win_rdata(win_rdata),
        .drop_count(drop_count)
    );

    typedef struct {
        logic [1:0] tgt;
        logic       we;
        logic [7:0] off;
        logic [7:0] wd;
        string      tag;
    } ev_t;

    ev_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Target code: 0 none, 1 system, 2 config, 3 window.
    function automatic logic [1:0] model_tgt(input logic [15:0] a);
        if (a[15:8] == 8'd0) return 2'd1;
        if (a[15:8] == 8'd1) return 2'd2;
        if (win_en && a[15:8] == win_base) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [7:0] model_rd(input logic [1:0] t, input logic [7:0] o);
        case (t)
            2'd1: return o ^ 8'h5A;
            2'd2: return o + 8'h30;
            2'd3: return ~o;
            default: return 8'h00;
        endcase
    endfunction

    // Monitor: compare each observed byte cycle against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && host_busy) begin
            logic [1:0] obs;
            obs = sys_sel ? 2'd1 : cfg_sel ? 2'd2 : win_sel ? 2'd3 : 2'd0;
            chk((32'(sys_sel) + 32'(cfg_sel) + 32'(win_sel)) <= 1, "R1",
                "more than one select", {29'd0, sys_sel, cfg_sel, win_sel}, 32'd0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "byte cycle with nothing expected", 32'(tgt_off), 32'd0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                chk(obs == e.tgt, e.tag, "target", 32'(obs), 32'(e.tgt));
                chk(tgt_off == e.off, e.tag, "offset", 32'(tgt_off), 32'(e.off));
                chk(tgt_we == e.we, e.tag, "write strobe", 32'(tgt_we), 32'(e.we));
                if (e.we)
                    chk(tgt_wdata == e.wd, "R7", "write byte", 32'(tgt_wdata), 32'(e.wd));
            end
        end
    end

    // Driver: queue expected bytes, issue the access, check timing and result.
    task automatic access(input logic we, input logic [1:0] size, input logic [15:0] addr,
                          input logic [31:0] wd, input string tag, input bit poke);
        int n;
        logic [31:0] exp_rd;
        n = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        exp_rd = '0;
        for (int k = 0; k < n; k++) begin
            logic [15:0] a;
            logic [1:0]  t;
            ev_t e;
            a = addr + 16'(k);
            t = model_tgt(a);
            e.tgt = t; e.we = we; e.off = a[7:0]; e.wd = wd[8*k +: 8];
            e.tag = (t == 2'd0) ? (we ? "R6" : "R5") : tag;
            exp_q.push_back(e);
            if (!we) exp_rd[8*k +: 8] = model_rd(t, a[7:0]);
            if (we && t == 2'd0 && exp_drops < 255) exp_drops++;
        end
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_size = size;
        host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        for (int c = 1; c <= n + 1; c++) begin
            if (poke && c == 2) begin
                host_req = 1'b1; host_addr = 16'h0005; host_we = 1'b0; host_size = 2'd2;
            end
            if (poke && c == 3) host_req = 1'b0;
            if (c <= n) begin
                chk(host_busy && !host_done, "R9", "busy during bytes",
                    {30'd0, host_busy, host_done}, 32'd2);
                @(negedge clk);
            end else begin
                chk(host_done && !host_busy, "R9", "done after last byte",
                    {30'd0, host_busy, host_done}, 32'd1);
                chk(host_rdata == exp_rd, (we ? "R8" : tag), "read word", host_rdata, exp_rd);
            end
        end
        @(negedge clk);
        chk(!host_done && !host_busy, "R9", "done is one pulse",
            {30'd0, host_busy, host_done}, 32'd0);
        chk(exp_q.size() == 0, "R7", "bytes left in scoreboard", 32'(exp_q.size()), 32'd0);
        chk(drop_count == 8'(exp_drops), "R6", "drop count", 32'(drop_count), 32'(exp_drops));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet reset state
        chk(!host_busy && !host_done, "R10", "busy/done after reset",
            {30'd0, host_busy, host_done}, 32'd0);
        chk(!(sys_sel || cfg_sel || win_sel), "R10", "selects after reset",
            {29'd0, sys_sel, cfg_sel, win_sel}, 32'd0);
        chk(host_rdata == 0 && drop_count == 0, "R10", "rdata/drops after reset",
            host_rdata | 32'(drop_count), 32'd0);

        // R1 system page, byte write then word read
        access(1'b1, 2'd0, 16'h0012, 32'h0000_00A5, "R1", 1'b0);
        access(1'b0, 2'd2, 16'h0040, 32'h0, "R1", 1'b0);
        // R2 config page half write and half read
        access(1'b1, 2'd1, 16'h0110, 32'h0000_C3D4, "R2", 1'b0);
        access(1'b0, 2'd1, 16'h0120, 32'h0, "R2", 1'b0);
        // R3 enabled window
        win_base = 8'h37; win_en = 1'b1;
        access(1'b0, 2'd2, 16'h3720, 32'h0, "R3", 1'b0);
        access(1'b1, 2'd2, 16'h37FC, 32'h1122_3344, "R3", 1'b0);
        // R3 disabled window: reads give zero (R5), writes drop (R6)
        win_en = 1'b0;
        access(1'b0, 2'd2, 16'h3720, 32'h0, "R3", 1'b0);
        access(1'b1, 2'd1, 16'h3730, 32'h0000_BEEF, "R6", 1'b0);
        // R8 byte read on unused page: upper lanes stay zero
        access(1'b0, 2'd0, 16'h9000, 32'h0, "R5", 1'b0);
        access(1'b0, 2'd0, 16'h0077, 32'h0, "R8", 1'b0);
        // R4 window placed on fixed pages
        win_base = 8'h01; win_en = 1'b1;
        access(1'b0, 2'd2, 16'h0104, 32'h0, "R4", 1'b0);
        win_base = 8'h00;
        access(1'b0, 2'd1, 16'h0008, 32'h0, "R4", 1'b0);
        // R7 word crossing from page 0 into page 1
        access(1'b0, 2'd2, 16'h00FE, 32'h0, "R7", 1'b0);
        // R7 wrap from window on top page into page 0
        win_base = 8'hFF;
        access(1'b0, 2'd2, 16'hFFFE, 32'h0, "R7", 1'b0);
        // R7 size code 3 behaves as a word
        access(1'b1, 2'd3, 16'h0030, 32'hDEAD_BEEF, "R7", 1'b0);
        // R9 request during busy is ignored
        access(1'b0, 2'd2, 16'h0150, 32'h0, "R9", 1'b1);
        // R6 saturation with many dropped word writes
        win_en = 1'b0;
        for (int i = 0; i < 70; i++)
            access(1'b1, 2'd2, 16'h5000, 32'(i), "R6", 1'b0);
        chk(drop_count == 8'hFF, "R6", "saturated drop count", 32'(drop_count), 32'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule